// File: doc/BRIEF.md
# Time Base and Decrementer Timer

This block keeps two free-running 64-bit time counters, a primary time base and an alternate time base with a value of its own. Both advance by one on every cycle in which the time-base tick enable is high. Alongside them sits a 32-bit decrementer that counts down on the same tick. When the decrementer runs out, or when software loads a negative value into a decrementer that held a non-negative one, the block raises an exception request. The request stays high until the core acknowledges it.

Software reaches all counters through one register port. Each 64-bit counter is written 32 bits at a time, and a write to one half leaves the other half as it was. A real-time-clock view gives a masked window onto the lower word of the primary time base, and a second view maps onto its upper word. A re-initialise input stands for start-up or a change of the tick frequency. It reloads the decrementer with all-ones and drops any pending request. Reads are combinational from the selected counter. Writes take effect at the next clock edge.

Top module: `timebase_dec`

## Requirements
- R1: After reset both time bases read 0, the decrementer reads 0xFFFFFFFF and `dec_irq` is low.
- R2: The primary time base increments by one, with carry across all 64 bits, on each clock edge where `tick_en` is high, and holds otherwise.
- R3: Selects 0 and 1 address the lower and upper 32 bits of the primary time base. A write through one of them replaces that half only and keeps the other half.
- R4: Selects 2 and 3 address the lower and upper halves of the alternate time base in the same way. The alternate base ticks with `tick_en`, and a write to it never changes the primary time base.
- R5: Select 4 reads and writes the decrementer. It decreases by one on each tick while it holds a non-zero value.
- R6: A tick while the decrementer holds 0 reloads it with 0xFFFFFFFF and sets `dec_irq` on the following cycle.
- R7: A decrementer write sets `dec_irq` when bit 31 of the written value is 1 and bit 31 of the old value was 0. Any other write leaves `dec_irq` unchanged.
- R8: `dec_ack` clears `dec_irq`. When a new cause of the request occurs in the same cycle as the acknowledge, the request stays set.
- R9: `reinit` loads the decrementer with 0xFFFFFFFF and clears `dec_irq`. It overrides a write, a tick or a set in the same cycle, and it does not touch either time base.
- R10: Select 5 reads the primary lower word ANDed with 0x3FFFFF80. A write through select 5 stores the written value ANDed with 0x3FFFFF80 into the lower word and keeps the upper word. Select 6 behaves exactly like select 1.
- R11: When a write and a tick fall in the same cycle, the written counter takes the written value and the tick is not applied to it. The counters that were not written still tick.
- R12: Select 7 reads 0, and a write to it changes no counter and no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Time-base tick enable, one count per cycle when high |
| reinit | input | 1 | Re-initialise the decrementer (start-up or frequency change) |
| dec_ack | input | 1 | Acknowledge that clears the decrementer request |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (encoding in R3, R4, R5, R10, R12) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| dec_irq | output | 1 | Decrementer exception request |

## Verification
Several events can land on the same clock edge. A register write can coincide with a tick, an expiry can coincide with an acknowledge, and a re-initialise can coincide with a pending request. The bench drives the write strobe and `tick_en` high together, for the time-base halves and for the decrementer, including a write while the decrementer sits at zero. It then reads back the written value, confirms that no expiry happened, and confirms that the counters not written still advanced by one. It also raises the acknowledge during the cycle that an expiry sets the request. It judges by the request level on the next cycle, which must stay high.

// File: rtl/tbd_pkg.sv
package tbd_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned SEL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_TB_LO  = 3'd0,
    SEL_TB_HI  = 3'd1,
    SEL_ALT_LO = 3'd2,
    SEL_ALT_HI = 3'd3,
    SEL_DEC    = 3'd4,
    SEL_RTC_LO = 3'd5,
    SEL_RTC_HI = 3'd6,
    SEL_NONE   = 3'd7
  } tbd_sel_e;

endpackage

// File: rtl/tbd_wide_ctr.sv
module tbd_wide_ctr #(
  parameter int unsigned HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_en,
  input  logic                  wr_lo,
  input  logic                  wr_hi,
  input  logic [HALF_W-1:0]     wdata,
  output logic [2*HALF_W-1:0]   count
);

  localparam int unsigned FULL_W = 2 * HALF_W;

  logic [FULL_W-1:0] cnt_q;
  logic [FULL_W-1:0] cnt_d;

  // Next state: a write to either half wins over the tick.
  always_comb begin
    cnt_d = cnt_q;
    if (wr_lo) begin
      cnt_d = {cnt_q[FULL_W-1:HALF_W], wdata};
    end else if (wr_hi) begin
      cnt_d = {wdata, cnt_q[HALF_W-1:0]};
    end else if (tick_en) begin
      cnt_d = cnt_q + {{(FULL_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/tbd_decrementer.sv
module tbd_decrementer #(
  parameter int unsigned DEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             reinit,
  input  logic             wr,
  input  logic [DEC_W-1:0] wdata,
  input  logic             ack,
  output logic [DEC_W-1:0] value,
  output logic             irq
);

  localparam int unsigned MSB = DEC_W - 1;

  logic [DEC_W-1:0] dec_q;
  logic [DEC_W-1:0] dec_d;
  logic             irq_q;
  logic             irq_d;
  logic             set_req;
  logic             at_zero;

  assign at_zero = (dec_q == '0);

  always_comb begin
    dec_d   = dec_q;
    set_req = 1'b0;
    if (wr) begin
      // Software load; a sign change from clear to set requests the exception.
      dec_d   = wdata;
      set_req = wdata[MSB] & ~dec_q[MSB];
    end else if (tick_en) begin
      if (at_zero) begin
        dec_d   = '1;
        set_req = 1'b1;
      end else begin
        dec_d = dec_q - {{(DEC_W-1){1'b0}}, 1'b1};
      end
    end
  end

  always_comb begin
    irq_d = set_req | (irq_q & ~ack);
    if (reinit) begin
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q <= '1;
      irq_q <= 1'b0;
    end else begin
      dec_q <= reinit ? {DEC_W{1'b1}} : dec_d;
      irq_q <= irq_d;
    end
  end

  assign value = dec_q;
  assign irq   = irq_q;

endmodule

// File: rtl/tbd_regport.sv
module tbd_regport
  import tbd_pkg::*;
#(
  parameter int unsigned W        = 32,
  parameter logic [W-1:0] RTC_MASK = 32'h3FFF_FF80
) (
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [W-1:0]      reg_wdata,
  input  logic [2*W-1:0]    tb_main,
  input  logic [2*W-1:0]    tb_alt,
  input  logic [W-1:0]      dec_val,
  output logic [1:0]        wr_lo,
  output logic [1:0]        wr_hi,
  output logic              dec_wr,
  output logic [W-1:0]      wdata_eff,
  output logic [W-1:0]      rdata
);

  tbd_sel_e sel;
  assign sel = tbd_sel_e'(reg_sel);

  // Write strobes, one per counter half.
  always_comb begin
    wr_lo  = 2'b00;
    wr_hi  = 2'b00;
    dec_wr = 1'b0;
    if (reg_wr) begin
      unique case (sel)
        SEL_TB_LO,
        SEL_RTC_LO: wr_lo[0] = 1'b1;
        SEL_TB_HI,
        SEL_RTC_HI: wr_hi[0] = 1'b1;
        SEL_ALT_LO: wr_lo[1] = 1'b1;
        SEL_ALT_HI: wr_hi[1] = 1'b1;
        SEL_DEC:    dec_wr   = 1'b1;
        default:    ;
      endcase
    end
  end

  assign wdata_eff = (sel == SEL_RTC_LO) ? (reg_wdata & RTC_MASK) : reg_wdata;

  // Read multiplexer.
  always_comb begin
    unique case (sel)
      SEL_TB_LO:  rdata = tb_main[W-1:0];
      SEL_TB_HI,
      SEL_RTC_HI: rdata = tb_main[2*W-1:W];
      SEL_ALT_LO: rdata = tb_alt[W-1:0];
      SEL_ALT_HI: rdata = tb_alt[2*W-1:W];
      SEL_DEC:    rdata = dec_val;
      SEL_RTC_LO: rdata = tb_main[W-1:0] & RTC_MASK;
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/timebase_dec.sv
module timebase_dec
  import tbd_pkg::*;
#(
  parameter int unsigned  W        = WORD_W,
  parameter logic [W-1:0] RTC_MASK = 32'h3FFF_FF80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             reinit,
  input  logic             dec_ack,
  input  logic             reg_wr,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [W-1:0]     reg_wdata,
  output logic [W-1:0]     reg_rdata,
  output logic             dec_irq
);

  localparam int unsigned NUM_TB = 2;
  localparam int unsigned TB_W   = 2 * W;

  logic [NUM_TB-1:0] wr_lo;
  logic [NUM_TB-1:0] wr_hi;
  logic              dec_wr;
  logic [W-1:0]      wdata_eff;
  logic [TB_W-1:0]   tb_cnt [NUM_TB];
  logic [W-1:0]      dec_val;

  // Index 0 is the primary time base, index 1 the alternate one.
  for (genvar g = 0; g < NUM_TB; g++) begin : g_tb
    tbd_wide_ctr #(.HALF_W(W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .wr_lo   (wr_lo[g]),
      .wr_hi   (wr_hi[g]),
      .wdata   (wdata_eff),
      .count   (tb_cnt[g])
    );
  end

  tbd_decrementer #(.DEC_W(W)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .reinit  (reinit),
    .wr      (dec_wr),
    .wdata   (wdata_eff),
    .ack     (dec_ack),
    .value   (dec_val),
    .irq     (dec_irq)
  );

  tbd_regport #(.W(W), .RTC_MASK(RTC_MASK)) u_port (
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .tb_main   (tb_cnt[0]),
    .tb_alt    (tb_cnt[1]),
    .dec_val   (dec_val),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .dec_wr    (dec_wr),
    .wdata_eff (wdata_eff),
    .rdata     (reg_rdata)
  );

endmodule

// File: rtl/tbd_checker.sv
module tbd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_en,
  input logic        reinit,
  input logic        dec_ack,
  input logic        reg_wr,
  input logic [2:0]  reg_sel,
  input logic [31:0] reg_wdata,
  input logic [63:0] tb_val,
  input logic [31:0] dec_val,
  input logic        dec_irq
);

  logic dec_wr_c;
  assign dec_wr_c = reg_wr && (reg_sel == 3'd4);

  AST_TB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !reg_wr) |=> (tb_val == $past(tb_val) + 64'd1)); // R2

  AST_TB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !reg_wr) |=> $stable(tb_val)); // R2

  AST_TBLO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 3'd0) |=> (tb_val[63:32] == $past(tb_val[63:32]))); // R3

  AST_ALT_NO_TOUCH: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_sel == 3'd2 || reg_sel == 3'd3) && !tick_en) |=> $stable(tb_val)); // R4

  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !dec_wr_c && !reinit && dec_val != 32'd0)
      |=> (dec_val == $past(dec_val) - 32'd1)); // R5

  AST_DEC_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !dec_wr_c && !reinit && dec_val == 32'd0)
      |=> (dec_val == 32'hFFFF_FFFF && dec_irq)); // R6

  AST_WR_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_wr_c && !reinit && reg_wdata[31] && !dec_val[31]) |=> dec_irq); // R7

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_irq && dec_ack && !tick_en && !reg_wr) |=> !dec_irq); // R8

  AST_REINIT: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> (dec_val == 32'hFFFF_FFFF && !dec_irq)); // R9

endmodule

bind timebase_dec tbd_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .reinit    (reinit),
  .dec_ack   (dec_ack),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .tb_val    (tb_cnt[0]),
  .dec_val   (dec_val),
  .dec_irq   (dec_irq)
);

// File: tb/sim_timebase_dec.sv
module sim_timebase_dec;

  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic        reinit;
  logic        dec_ack;
  logic        reg_wr;
  logic [2:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        dec_irq;

  int checks   = 0;
  int failures = 0;
  logic [31:0] saved;

  timebase_dec u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .reinit    (reinit),
    .dec_ack   (dec_ack),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .dec_irq   (dec_irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Row: {req[3:0], tick, wr, sel[2:0], wdata[31:0], reinit, ack, rd_sel[2:0], exp[31:0], exp_irq}
  localparam int NV = 21;
  localparam logic [78:0] VEC [NV] = '{
    {4'd2,  1'b1, 1'b0, 3'd0, 32'h0,          1'b0, 1'b0, 3'd0, 32'h0000_0001, 1'b0}, // R2 tick
    {4'd3,  1'b0, 1'b1, 3'd1, 32'h0000_0005,  1'b0, 1'b0, 3'd1, 32'h0000_0005, 1'b0}, // R3 upper write
    {4'd3,  1'b0, 1'b0, 3'd0, 32'h0,          1'b0, 1'b0, 3'd0, 32'h0000_0001, 1'b0}, // R3 lower kept
    {4'd11, 1'b1, 1'b1, 3'd0, 32'hFFFF_FFFF,  1'b0, 1'b0, 3'd0, 32'hFFFF_FFFF, 1'b0}, // R11 write beats tick
    {4'd2,  1'b1, 1'b0, 3'd0, 32'h0,          1'b0, 1'b0, 3'd1, 32'h0000_0006, 1'b0}, // R2 carry
    {4'd11, 1'b0, 1'b0, 3'd0, 32'h0,          1'b0, 1'b0, 3'd2, 32'h0000_0003, 1'b0}, // R11 alt still ticked
    {4'd4,  1'b0, 1'b1, 3'd3, 32'h0000_00A5,  1'b0, 1'b0, 3'd3, 32'h0000_00A5, 1'b0}, // R4 alt upper
    {4'd4,  1'b0, 1'b0, 3'd0, 32'h0,          1'b0, 1'b0, 3'd0, 32'h0000_0000, 1'b0}, // R4 primary untouched
    {4'd7,  1'b0, 1'b1, 3'd4, 32'h0000_0002,  1'b0, 1'b0, 3'd4, 32'h0000_0002, 1'b0}, // R7 positive load
    {4'd5,  1'b1, 1'b0, 3'd0, 32'h0,          1'b0, 1'b0, 3'd4, 32'h0000_0001, 1'b0}, // R5
    {4'd5,  1'b1, 1'b0, 3'd0, 32'h0,          1'b0, 1'b0, 3'd4, 32'h0000_0000, 1'b0}, // R5
    {4'd6,  1'b1, 1'b0, 3'd0, 32'h0,          1'b0, 1'b0, 3'd4, 32'hFFFF_FFFF, 1'b1}, // R6 expiry
    {4'd8,  1'b0, 1'b0, 3'd0, 32'h0,          1'b0, 1'b1, 3'd4, 32'hFFFF_FFFF, 1'b0}, // R8 ack
    {4'd7,  1'b0, 1'b1, 3'd4, 32'h8000_0000,  1'b0, 1'b0, 3'd4, 32'h8000_0000, 1'b0}, // R7 negative over negative
    {4'd7,  1'b0, 1'b1, 3'd4, 32'h0000_0010,  1'b0, 1'b0, 3'd4, 32'h0000_0010, 1'b0}, // R7
    {4'd7,  1'b0, 1'b1, 3'd4, 32'h8000_0000,  1'b0, 1'b0, 3'd4, 32'h8000_0000, 1'b1}, // R7 sign change
    {4'd10, 1'b0, 1'b0, 3'd0, 32'h0,          1'b0, 1'b1, 3'd5, 32'h0000_0000, 1'b0}, // R10 masked read
    {4'd10, 1'b0, 1'b1, 3'd5, 32'hFFFF_FFFF,  1'b0, 1'b0, 3'd0, 32'h3FFF_FF80, 1'b0}, // R10 masked write
    {4'd10, 1'b0, 1'b0, 3'd0, 32'h0,          1'b0, 1'b0, 3'd6, 32'h0000_0006, 1'b0}, // R10 upper view
    {4'd12, 1'b0, 1'b1, 3'd7, 32'h1234_5678,  1'b0, 1'b0, 3'd7, 32'h0000_0000, 1'b0}, // R12
    {4'd12, 1'b0, 1'b0, 3'd0, 32'h0,          1'b0, 1'b0, 3'd0, 32'h3FFF_FF80, 1'b0}  // R12 no effect
  };

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, return at the next falling edge.
  task automatic step(input logic t, input logic w, input logic [2:0] s,
                      input logic [31:0] d, input logic ri, input logic ak);
    tick_en = t; reg_wr = w; reg_sel = s; reg_wdata = d; reinit = ri; dec_ack = ak;
    @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0; reg_wr = 1'b0; reinit = 1'b0; dec_ack = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    reg_sel = s;
    #1;
    v = reg_rdata;
  endtask

  initial begin : watchdog
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    rst_n = 1'b0; tick_en = 1'b0; reinit = 1'b0; dec_ack = 1'b0;
    reg_wr = 1'b0; reg_sel = 3'd0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); check(1, "reset tb lo", v, 32'h0);
    rd(3'd3, v); check(1, "reset alt hi", v, 32'h0);
    rd(3'd4, v); check(1, "reset dec", v, 32'hFFFF_FFFF);
    check(1, "reset irq", {31'd0, dec_irq}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [78:0] r;
      r = VEC[i];
      step(r[74], r[73], r[72:70], r[69:38], r[37], r[36]);
      rd(r[35:33], v);
      check(int'(r[78:75]), $sformatf("vector %0d data", i), v, r[32:1]);
      check(int'(r[78:75]), $sformatf("vector %0d irq", i), {31'd0, dec_irq}, {31'd0, r[0]});
    end

    // R8: expiry and acknowledge in the same cycle keep the request
    step(1'b0, 1'b1, 3'd4, 32'h0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 3'd0, 32'h0, 1'b0, 1'b1);
    check(8, "set beats ack", {31'd0, dec_irq}, 32'd1);

    // R9: reinit clears the request, reloads, leaves the time base
    rd(3'd0, saved);
    step(1'b0, 1'b1, 3'd4, 32'h0000_0003, 1'b1, 1'b0);
    rd(3'd4, v); check(9, "reinit dec", v, 32'hFFFF_FFFF);
    check(9, "reinit irq", {31'd0, dec_irq}, 32'd0);
    rd(3'd0, v); check(9, "reinit tb kept", v, saved);

    // R11: decrementer write at zero together with a tick: no expiry
    step(1'b0, 1'b1, 3'd4, 32'h0, 1'b0, 1'b0);
    rd(3'd0, saved);
    step(1'b1, 1'b1, 3'd4, 32'h0000_0009, 1'b0, 1'b0);
    rd(3'd4, v); check(11, "dec write beats tick", v, 32'h0000_0009);
    check(11, "no expiry on write", {31'd0, dec_irq}, 32'd0);
    rd(3'd0, v); check(11, "tb ticked", v, saved + 32'd1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule